// File: doc/BRIEF.md
# Host Mailbox Ring Controller

This block is the host side of a two-party mailbox. Each direction has its own circular buffer of 32-bit slots. The host writes outbound slots through one window address and pops inbound slots through another. Both buffers are tracked with free-running 8-bit read and write pointers. The host sees these pointers, together with the buffer depth, in a 32-bit status word. Software computes occupancy as the pointer difference modulo 256, and free space as depth minus occupancy.

The peer side is a plain port. The peer pops outbound slots, pushes inbound slots, signals interrupts towards the host, and shows a ready level. The host control word carries these functions:
- interrupt enable;
- a write-one-to-acknowledge interrupt status;
- a self-clearing interrupt-generate pulse to the peer;
- a ready flag;
- a reset flag that flushes both buffers;
- a sticky overflow flag.

Bring-up follows this sequence. The host sets reset together with interrupt-generate. It then waits for the peer's ready bit. Finally it writes ready plus interrupt-generate with reset cleared.

Top module: `mbx_host_window`

## Requirements
- R1: Each host write to offset 0x00 (address bits [3:2] = 0) appends one 32-bit word to the outbound buffer. The peer receives the words in write order on `out_data` while `out_avail` is high, and each `out_pop` advances the head. The outbound write pointer (status bits [23:16]) increments by one per accepted word.
- R2: A window write while the outbound buffer holds DEPTH words is dropped and leaves the write pointer unchanged. It sets sticky overflow at host status bit 5. Writing the host status word with bit 5 set clears that flag.
- R3: The pointers are 8 bits and wrap at 256. The read pointer is in bits [15:8] and the depth in bits [31:24]. Filled slots equal (write pointer − read pointer) mod 256, and free slots equal depth minus filled, including across a pointer wrap.
- R4: A host read of offset 0x08 pops the oldest inbound word and advances the inbound read pointer. Each host read returns its data on `host_rdata` in the cycle after the access.
- R5: A read of offset 0x08 while the inbound buffer is empty returns 0 and leaves the inbound read pointer unchanged.
- R6: A one-cycle `peer_irq_in` sets interrupt status (host status bit 1). `host_irq` is high while interrupt enable (bit 0) and interrupt status are both set. Writing the host status word with bit 1 set clears the status. A peer set in the same cycle wins.
- R7: Writing 1 to host status bit 2 raises `peer_irq_out` for exactly the one cycle after the write. Writing 0 has no effect, and bit 2 always reads 0.
- R8: While host reset (bit 4) is set, both buffers are flushed so that each read pointer equals its write pointer. Outbound window writes and peer pushes are dropped.
- R9: After reset, both status words read DEPTH in bits [31:24] and zero everywhere else.
- R10: The peer status word at offset 0x0C shows `peer_ready` in bit 3 and the inbound pointers in bits [15:8] and [23:16]. Host ready is bit 3 of the host status word at 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Byte offset; bits [3:2] select the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid the cycle after a read access |
| host_irq | output | 1 | Interrupt to host (enable AND status) |
| out_avail | output | 1 | Outbound buffer holds at least one word |
| out_data | output | 32 | Oldest outbound word |
| out_pop | input | 1 | Peer consumes the outbound head |
| in_push | input | 1 | Peer writes one inbound word |
| in_data | input | 32 | Inbound word from the peer |
| in_full | output | 1 | Inbound buffer is full |
| peer_ready | input | 1 | Peer ready level |
| peer_irq_in | input | 1 | Peer interrupt request pulse |
| peer_irq_out | output | 1 | One-cycle interrupt pulse to the peer |

## Verification
Every host-visible effect lands at the clock edge that samples the access. A pointer change, a flag change or `peer_irq_out` is therefore visible at the following falling edge, and read data appears on `host_rdata` one cycle after the read strobe. The bench drives on falling edges and samples exactly one falling edge after each access. This catches a pulse that lasts two cycles or arrives late. Outbound words go into a scoreboard queue when the driver issues them, and a monitor pops and compares them as the peer drains the buffer. Pointer fields are read back through the status words after each stimulus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PTR_W  = 8;

  // status word bit positions
  localparam int unsigned B_IEN  = 0;
  localparam int unsigned B_IST  = 1;
  localparam int unsigned B_IGEN = 2;
  localparam int unsigned B_RDY  = 3;
  localparam int unsigned B_RST  = 4;
  localparam int unsigned B_OVF  = 5;

  typedef enum logic [1:0] {
    REG_OUT_WIN   = 2'd0,
    REG_HOST_STAT = 2'd1,
    REG_IN_WIN    = 2'd2,
    REG_PEER_STAT = 2'd3
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic [PTR_W-1:0] depth, input logic [PTR_W-1:0] wp,
    input logic [PTR_W-1:0] rp, input logic [7:0] flags);
    return {depth, wp, rp, flags};
  endfunction
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [7:0]        rd_ptr,
  output logic [7:0]        wr_ptr,
  output logic [7:0]        fill,
  output logic              full,
  output logic              empty,
  output logic              drop
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [7:0]  DEPTH_P = 8'(DEPTH);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [7:0] rd_nxt, wr_nxt;
  logic       do_push, do_pop;

  assign fill  = wr_ptr - rd_ptr;
  assign full  = (fill == DEPTH_P);
  assign empty = (fill == 8'd0);
  assign head  = slot_q[rd_ptr[IDX_W-1:0]];
  assign drop  = push && full && !flush;

  always_comb begin
    do_push = push && !full && !flush;
    do_pop  = pop && !empty && !flush;
    wr_nxt  = do_push ? wr_ptr + 8'd1 : wr_ptr;
    rd_nxt  = flush ? wr_ptr : (do_pop ? rd_ptr + 8'd1 : rd_ptr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      rd_ptr <= rd_nxt;
      wr_ptr <= wr_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_ptr[IDX_W-1:0] == IDX_W'(g)))
        slot_q[g] <= push_data;
    end
  end

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH_P);
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> $stable(wr_ptr));
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !flush) |=> $stable(rd_ptr));
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rd_ptr == wr_ptr));
endmodule

// File: rtl/mbx_ctl.sv
module mbx_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stat_we,
  input  logic [31:0] wdata,
  input  logic        peer_irq_in,
  input  logic        ovf_set,
  output logic        ien,
  output logic        ist,
  output logic        rdy,
  output logic        rst_flag,
  output logic        ovf,
  output logic        irq,
  output logic        ig_pulse
);
  import mbx_pkg::*;

  logic ien_n, ist_n, rdy_n, rst_n_flag, ovf_n, ig_n;

  always_comb begin
    ien_n      = ien;
    rdy_n      = rdy;
    rst_n_flag = rst_flag;
    ist_n      = ist;
    ovf_n      = ovf;
    ig_n       = 1'b0;
    if (stat_we) begin
      ien_n      = wdata[B_IEN];
      rdy_n      = wdata[B_RDY];
      rst_n_flag = wdata[B_RST];
      ig_n       = wdata[B_IGEN];
      if (wdata[B_IST]) ist_n = 1'b0;
      if (wdata[B_OVF]) ovf_n = 1'b0;
    end
    if (peer_irq_in) ist_n = 1'b1;
    if (ovf_set)     ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien      <= 1'b0;
      ist      <= 1'b0;
      rdy      <= 1'b0;
      rst_flag <= 1'b0;
      ovf      <= 1'b0;
      ig_pulse <= 1'b0;
    end else begin
      ien      <= ien_n;
      ist      <= ist_n;
      rdy      <= rdy_n;
      rst_flag <= rst_n_flag;
      ovf      <= ovf_n;
      ig_pulse <= ig_n;
    end
  end

  assign irq = ien && ist;

  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && wdata[B_IST] && !peer_irq_in) |=> !ist);
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    peer_irq_in |=> ist);
  p_ig_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ig_pulse |-> $past(stat_we && wdata[B_IGEN]));
  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(stat_we && wdata[B_OVF])) |=> ovf);
endmodule

// File: rtl/mbx_host_window.sv
module mbx_host_window #(
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_we,
  input  logic [3:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_irq,
  output logic        out_avail,
  output logic [31:0] out_data,
  input  logic        out_pop,
  input  logic        in_push,
  input  logic [31:0] in_data,
  output logic        in_full,
  input  logic        peer_ready,
  input  logic        peer_irq_in,
  output logic        peer_irq_out
);
  import mbx_pkg::*;

  localparam logic [7:0] DEPTH_F = 8'(DEPTH);

  reg_sel_e   rsel;
  logic       wr_acc, rd_acc;
  logic       ien, ist, rdy, rst_flag, ovf, ob_drop;
  logic [7:0] ob_rp, ob_wp, ob_fill, ib_rp, ib_wp, ib_fill;
  logic       ob_full, ob_empty, ib_full, ib_empty, ib_drop;
  logic [31:0] ib_head, rdata_n;
  logic [7:0]  host_flags, peer_flags;

  assign rsel   = reg_sel_e'(host_addr[3:2]);
  assign wr_acc = host_sel && host_we;
  assign rd_acc = host_sel && !host_we;

  mbx_ring #(.DEPTH(DEPTH), .DATA_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .flush(rst_flag),
    .push(wr_acc && (rsel == REG_OUT_WIN)), .push_data(host_wdata),
    .pop(out_pop), .head(out_data), .rd_ptr(ob_rp), .wr_ptr(ob_wp),
    .fill(ob_fill), .full(ob_full), .empty(ob_empty), .drop(ob_drop));

  mbx_ring #(.DEPTH(DEPTH), .DATA_W(WORD_W)) u_in (
    .clk(clk), .rst_n(rst_n), .flush(rst_flag),
    .push(in_push), .push_data(in_data),
    .pop(rd_acc && (rsel == REG_IN_WIN)), .head(ib_head),
    .rd_ptr(ib_rp), .wr_ptr(ib_wp), .fill(ib_fill), .full(ib_full),
    .empty(ib_empty), .drop(ib_drop));

  mbx_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .stat_we(wr_acc && (rsel == REG_HOST_STAT)), .wdata(host_wdata),
    .peer_irq_in(peer_irq_in), .ovf_set(ob_drop),
    .ien(ien), .ist(ist), .rdy(rdy), .rst_flag(rst_flag), .ovf(ovf),
    .irq(host_irq), .ig_pulse(peer_irq_out));

  assign out_avail = !ob_empty;
  assign in_full   = ib_full;

  always_comb begin
    host_flags        = '0;
    host_flags[B_IEN] = ien;
    host_flags[B_IST] = ist;
    host_flags[B_RDY] = rdy;
    host_flags[B_RST] = rst_flag;
    host_flags[B_OVF] = ovf;
    peer_flags        = '0;
    peer_flags[B_RDY] = peer_ready;
  end

  always_comb begin
    unique case (rsel)
      REG_HOST_STAT: rdata_n = pack_status(DEPTH_F, ob_wp, ob_rp, host_flags);
      REG_IN_WIN:    rdata_n = (ib_empty || rst_flag) ? '0 : ib_head;
      REG_PEER_STAT: rdata_n = pack_status(DEPTH_F, ib_wp, ib_rp, peer_flags);
      default:       rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      host_rdata <= '0;
    else if (rd_acc) host_rdata <= rdata_n;
  end

  p_drop_pointer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ob_drop |=> ovf);
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (rsel == REG_IN_WIN) && ib_empty) |=> (host_rdata == 32'd0));
endmodule

// File: tb/sim_mbx_host_window.sv
module sim_mbx_host_window;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [31:0] host_wdata = '0, in_data = '0;
  logic [31:0] host_rdata, out_data;
  logic host_irq, out_avail, in_full, peer_irq_out;
  logic out_pop = 1'b0, in_push = 1'b0, peer_ready = 1'b0, peer_irq_in = 1'b0;

  int n_chk = 0, n_bad = 0;
  int out_cnt = 0;
  bit drain = 1'b0;
  logic [31:0] q_out[$];
  logic [31:0] q_in[$];
  logic [31:0] s, p;

  always #2.5 clk = ~clk;

  mbx_host_window #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .out_avail(out_avail), .out_data(out_data),
    .out_pop(out_pop), .in_push(in_push), .in_data(in_data), .in_full(in_full),
    .peer_ready(peer_ready), .peer_irq_in(peer_irq_in), .peer_irq_out(peer_irq_out));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_sel = 1'b0;
  endtask

  // driver: issue an outbound word and record it in the scoreboard
  task automatic send_word(input logic [31:0] d, input bit accepted);
    host_write(4'h0, d);
    if (accepted) begin
      q_out.push_back(d);
      out_cnt++;
    end
  endtask

  task automatic peer_push(input logic [31:0] d, input bit accepted);
    @(negedge clk);
    in_push = 1'b1; in_data = d;
    @(negedge clk);
    in_push = 1'b0;
    if (accepted) q_in.push_back(d);
  endtask

  task automatic stop_drain();
    drain = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_drained();
    drain = 1'b1;
    repeat (3 * DEPTH + 4) @(negedge clk);
  endtask

  // monitor: pop outbound words and compare with the scoreboard
  always @(negedge clk) begin
    if (drain && out_avail) begin
      if (q_out.size() == 0) check(1'b0, "R1 unexpected word", out_data, 32'h0);
      else begin
        logic [31:0] e;
        e = q_out.pop_front();
        check(out_data == e, "R1 order", out_data, e);
      end
      out_pop <= 1'b1;
    end else out_pop <= 1'b0;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] fill;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    host_read(4'h4, s);
    check(s == 32'h0800_0000, "R9 host status", s, 32'h0800_0000);
    host_read(4'hC, p);
    check(p == 32'h0800_0000, "R9 peer status", p, 32'h0800_0000);

    // R2 fill to full, then overflow
    stop_drain();
    for (int i = 0; i < DEPTH; i++) send_word(32'hA000_0000 + i, 1'b1);
    send_word(32'hDEAD_BEEF, 1'b0);
    host_read(4'h4, s);
    check(s[5] == 1'b1, "R2 overflow flag", {31'h0, s[5]}, 32'h1);
    check(s[23:16] == 8'd8, "R2 wp unchanged on drop", {24'h0, s[23:16]}, 32'd8);
    fill = s[23:16] - s[15:8];
    check(fill == 8'd8 && (s[31:24] - fill) == 8'd0, "R3 full fill/free",
          {24'h0, fill}, 32'd8);
    wait_drained();
    check(q_out.size() == 0, "R1 all delivered", q_out.size(), 32'h0);
    host_read(4'h4, s);
    check(s[5] == 1'b1, "R2 overflow sticky", {31'h0, s[5]}, 32'h1);
    host_write(4'h4, 32'h20);
    host_read(4'h4, s);
    check(s[5] == 1'b0, "R2 overflow cleared", {31'h0, s[5]}, 32'h0);

    // R3 pointer wrap
    while (out_cnt != 254) send_word(32'h5000_0000 + out_cnt, 1'b1);
    wait_drained();
    stop_drain();
    for (int i = 0; i < 3; i++) send_word(32'h7700_0000 + i, 1'b1);
    host_read(4'h4, s);
    check(s[23:16] == 8'd1 && s[15:8] == 8'd254, "R3 wrapped pointers",
          {16'h0, s[23:8]}, 32'h01FE);
    fill = s[23:16] - s[15:8];
    check(fill == 8'd3, "R3 fill across wrap", {24'h0, fill}, 32'd3);
    check((s[31:24] - fill) == 8'd5, "R3 free across wrap",
          {24'h0, s[31:24] - fill}, 32'd5);
    wait_drained();
    check(q_out.size() == 0, "R1 wrap delivered", q_out.size(), 32'h0);

    // R4 inbound reads, R5 empty read
    peer_push(32'h1111_0001, 1'b1);
    peer_push(32'h1111_0002, 1'b1);
    peer_push(32'h1111_0003, 1'b1);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] e;
      host_read(4'h8, d);
      e = q_in.pop_front();
      check(d == e, "R4 inbound order", d, e);
    end
    host_read(4'hC, p);
    check(p[15:8] == 8'd3 && p[23:16] == 8'd3, "R10 inbound pointers",
          {16'h0, p[23:8]}, 32'h0303);
    host_read(4'h8, d);
    check(d == 32'h0, "R5 empty read zero", d, 32'h0);
    host_read(4'hC, p);
    check(p[15:8] == 8'd3, "R5 rp unchanged", {24'h0, p[15:8]}, 32'd3);

    // R6 interrupt status and acknowledge
    host_write(4'h4, 32'h1);
    @(negedge clk); peer_irq_in = 1'b1;
    @(negedge clk); peer_irq_in = 1'b0;
    check(host_irq == 1'b1, "R6 irq raised", {31'h0, host_irq}, 32'h1);
    host_read(4'h4, s);
    check(s[1:0] == 2'b11, "R6 status set", {30'h0, s[1:0]}, 32'h3);
    host_write(4'h4, 32'h3);
    check(host_irq == 1'b0, "R6 irq acked", {31'h0, host_irq}, 32'h0);
    host_write(4'h4, 32'h0);
    @(negedge clk); peer_irq_in = 1'b1;
    @(negedge clk); peer_irq_in = 1'b0;
    check(host_irq == 1'b0, "R6 irq masked", {31'h0, host_irq}, 32'h0);
    host_read(4'h4, s);
    check(s[1] == 1'b1, "R6 status while masked", {31'h0, s[1]}, 32'h1);
    host_write(4'h4, 32'h2);

    // R7 interrupt generate pulse
    host_write(4'h4, 32'h4);
    check(peer_irq_out == 1'b1, "R7 pulse high", {31'h0, peer_irq_out}, 32'h1);
    @(negedge clk);
    check(peer_irq_out == 1'b0, "R7 pulse self-clears", {31'h0, peer_irq_out}, 32'h0);
    host_read(4'h4, s);
    check(s[2] == 1'b0, "R7 reads zero", {31'h0, s[2]}, 32'h0);
    host_write(4'h4, 32'h0);
    check(peer_irq_out == 1'b0, "R7 write zero no pulse", {31'h0, peer_irq_out}, 32'h0);

    // R8 reset flush and handshake
    stop_drain();
    send_word(32'hC0DE_0001, 1'b1);
    send_word(32'hC0DE_0002, 1'b1);
    peer_push(32'hBEEF_0001, 1'b0);
    host_write(4'h4, 32'h14);
    check(peer_irq_out == 1'b1, "R7 pulse with reset", {31'h0, peer_irq_out}, 32'h1);
    host_read(4'h4, s);
    check(s[15:8] == s[23:16] && s[4], "R8 outbound flushed", {16'h0, s[23:8]}, {16'h0, s[23:16], s[23:16]});
    host_read(4'hC, p);
    check(p[15:8] == p[23:16], "R8 inbound flushed", {16'h0, p[23:8]}, {16'h0, p[23:16], p[23:16]});
    d = {24'h0, s[23:16]};
    host_write(4'h0, 32'h9999_9999);
    host_read(4'h4, s);
    check({24'h0, s[23:16]} == d, "R8 write dropped in reset", {24'h0, s[23:16]}, d);
    d = {24'h0, p[23:16]};
    peer_push(32'h8888_8888, 1'b0);
    host_read(4'hC, p);
    check({24'h0, p[23:16]} == d, "R8 push dropped in reset", {24'h0, p[23:16]}, d);
    q_out.delete();
    peer_ready = 1'b1;
    host_read(4'hC, p);
    check(p[3] == 1'b1, "R10 peer ready bit", {31'h0, p[3]}, 32'h1);
    host_write(4'h4, 32'h0C);
    host_read(4'h4, s);
    check(s[4:3] == 2'b01, "R10 host ready set, reset cleared", {30'h0, s[4:3]}, 32'h1);
    send_word(32'h1234_5678, 1'b1);
    wait_drained();
    check(q_out.size() == 0, "R1 traffic after handshake", q_out.size(), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule